// File: doc/BRIEF.md
# Rotating-Priority Distributed Bus Arbiter Node

This block is the arbiter placed in each node of a shared bus that has no central controller. Every node keeps its own priority level. The nodes start at distinct levels, and each node advances its level by one on every arbitration round. During a round, every node drives a run-length priority code onto a shared arbitration bus. The bus is the bitwise AND of all driven codes, so the code with the most zeros is the one that remains.

A node that has a pending request drives the code for its current level. A node with nothing to send drives the weakest code. Each node then compares the bus value it reads back against the code it drove, and decides on its own whether it has won. Because the levels are unique and rotate in lock-step, exactly one requester wins each round. Every requester reaches the top level within k rounds, so no node can starve.

Top module: `rot_prio_node`

## Requirements
- R1: After reset, `win` and `result_valid` are low and the node's level equals its `START_LEVEL` parameter.
- R2: With `req` high, `prio_code` for level L has bits [L-1:0] at zero and bits [NODES-2:L] at one. Level 0 is all ones (lowest priority) and level NODES-1 is all zeros (highest priority).
- R3: With `req` low, `prio_code` is all ones, whatever the level.
- R4: Each cycle with `arb_stb` high raises the level by one, whatever the state of `req`. Level NODES-1 wraps to 0.
- R5: On a strobe cycle, `win` is registered as high exactly when `req` is high and `bus_rd` equals `prio_code`. The result appears on the following cycle, together with a one-cycle `result_valid` pulse.
- R6: A node whose `req` is low in the strobe cycle never asserts `win`, even when its code matches the readback.
- R7: Without `arb_stb`, the level and `win` hold their values and `result_valid` stays low.
- R8: On a bus of nodes with distinct start levels, whose bus input is the AND of all codes, exactly one node wins in each round with at least one request. No node wins in a round with no requests. The winner is the requester holding the highest level.
- R9: A node that requests in every round wins within at most NODES rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_stb | input | 1 | Arbitration round strobe |
| req | input | 1 | Node has a pending transfer |
| prio_code | output | NODES-1 | Code driven onto the AND bus |
| bus_rd | input | NODES-1 | AND of all nodes' codes, read back |
| win | output | 1 | Node won the last round |
| result_valid | output | 1 | One-cycle pulse after each round |

## Verification
The hardest case to reach is a requesting node at a low level winning because every node above it is idle. This needs a specific alignment of the rotation and the request pattern. The bench tracks the round count, so it knows every node's level. It then raises only the requests that place the lone or weakest requester at the bottom of the ring. Both a 4-node and an 8-node bus run in lock-step from the same strobe. The rotation is also carried across its wrap point with mixed and empty request sets.

// File: rtl/rot_prio_node.sv
module rot_prio_node #(
  parameter int NODES       = 4,
  parameter int START_LEVEL = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_stb,
  input  logic               req,
  output logic [NODES-2:0]   prio_code,
  input  logic [NODES-2:0]   bus_rd,
  output logic               win,
  output logic               result_valid
);
  localparam int W  = NODES - 1;
  localparam int LW = (NODES > 2) ? $clog2(NODES) : 1;
  localparam logic [LW-1:0] TOP = LW'(NODES - 1);

  logic [LW-1:0] level;
  logic [W-1:0]  lvl_code;

  for (genvar b = 0; b < W; b++) begin : g_code
    assign lvl_code[b] = (level <= LW'(b));
  end

  assign prio_code = req ? lvl_code : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level        <= LW'(START_LEVEL);
      win          <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= arb_stb;
      if (arb_stb) begin
        level <= (level == TOP) ? '0 : level + 1'b1;
        win   <= req && (bus_rd == prio_code);
      end
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_stb && level == TOP) |=> level == '0);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_stb && level != TOP) |=> level == $past(level) + 1'b1);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_stb |=> ($stable(level) && $stable(win) && !result_valid));
  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_stb |=> result_valid);
  assert_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_stb && bus_rd != prio_code) |=> !win);
  assert_idle_nowin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_stb && !req) |=> !win);
  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> prio_code == '1);
endmodule

// File: tb/tb_rot_prio_node.sv
`timescale 1ns/1ps
module tb_rot_prio_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [3:0] r4 = '0;
  logic [7:0] r8 = '0;
  logic [2:0] c4 [4];
  logic [6:0] c8 [8];
  logic [2:0] bus4;
  logic [6:0] bus8;
  logic [3:0] w4, v4;
  logic [7:0] w8, v8;
  int n_chk = 0, n_bad = 0, rounds = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g4
    rot_prio_node #(.NODES(4), .START_LEVEL(i)) dut (
      .clk(clk), .rst_n(rst_n), .arb_stb(stb), .req(r4[i]),
      .prio_code(c4[i]), .bus_rd(bus4), .win(w4[i]), .result_valid(v4[i]));
  end
  for (genvar i = 0; i < 8; i++) begin : g8
    rot_prio_node #(.NODES(8), .START_LEVEL(i)) dut (
      .clk(clk), .rst_n(rst_n), .arb_stb(stb), .req(r8[i]),
      .prio_code(c8[i]), .bus_rd(bus8), .win(w8[i]), .result_valid(v8[i]));
  end

  always_comb begin
    bus4 = '1;
    for (int i = 0; i < 4; i++) bus4 = bus4 & c4[i];
    bus8 = '1;
    for (int i = 0; i < 8; i++) bus8 = bus8 & c8[i];
  end

  function automatic logic [6:0] thermo(input int k, input int lv);
    logic [6:0] v = '0;
    for (int b = 0; b < k - 1; b++) v[b] = (b >= lv);
    return v;
  endfunction

  function automatic int exp_winner(input int k, input logic [7:0] r, input int n);
    int best = -1, bl = -1;
    for (int i = 0; i < k; i++)
      if (r[i] && ((i + n) % k) > bl) begin bl = (i + n) % k; best = i; end
    return best;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_codes();
    for (int i = 0; i < 4; i++)
      chk(c4[i] == (r4[i] ? thermo(4, (i + rounds) % 4) : 7'h7),
          r4[i] ? "R2/R4 code k4" : "R3 idle code k4", c4[i],
          r4[i] ? thermo(4, (i + rounds) % 4) : 7'h7);
    for (int i = 0; i < 8; i++)
      chk(c8[i] == (r8[i] ? thermo(8, (i + rounds) % 8) : 7'h7f),
          r8[i] ? "R2/R4 code k8" : "R3 idle code k8", c8[i],
          r8[i] ? thermo(8, (i + rounds) % 8) : 7'h7f);
  endtask

  task automatic do_round(input logic [3:0] q4, input logic [7:0] q8);
    int e4, e8;
    @(negedge clk);
    r4 = q4; r8 = q8;
    #0.5;
    check_codes();
    e4 = exp_winner(4, {4'b0, q4}, rounds);
    e8 = exp_winner(8, q8, rounds);
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    rounds++;
    chk(v4 == 4'hf && v8 == 8'hff, "R5 result_valid", {v8, v4}, 12'hfff);
    chk(w4 == ((e4 < 0) ? 4'h0 : 4'(1 << e4)), "R8 winner k4", w4,
        (e4 < 0) ? 0 : (1 << e4));
    chk(w8 == ((e8 < 0) ? 8'h0 : 8'(1 << e8)), "R8 winner k8", w8,
        (e8 < 0) ? 0 : (1 << e8));
    chk((w4 & ~q4) == 0 && (w8 & ~q8) == 0, "R6 no win without req",
        {w8 & ~q8, w4 & ~q4}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(w4 == 0 && w8 == 0, "R1 win after reset", {w8, w4}, 0);
    chk(v4 == 0 && v8 == 0, "R1 valid after reset", {v8, v4}, 0);
    r4 = '1; r8 = '1;
    #0.5;
    check_codes();
    chk(c4[3] == 3'b000 && c4[0] == 3'b111, "R1 start levels k4", {c4[3], c4[0]}, 3'b111);
    r4 = '0; r8 = '0;
    #0.5;
    check_codes();
  endtask

  task automatic t_hold();
    logic [3:0] h4;
    logic [7:0] h8;
    h4 = w4; h8 = w8;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      r4 = 4'(c * 5); r8 = 8'(c * 37);
      #0.5;
      chk(w4 == h4 && w8 == h8, "R7 win holds", {w8, w4}, {h8, h4});
      chk(v4 == 0 && v8 == 0, "R7 valid low", {v8, v4}, 0);
    end
    r4 = '1; r8 = '1;
    #0.5;
    check_codes();
  endtask

  task automatic t_lone_low();
    int l0;
    l0 = (4 - (rounds % 4)) % 4;
    do_round(4'(1 << l0), 8'h01 << ((8 - (rounds % 8)) % 8));
    chk(w4[l0] == 1'b1, "R8 lone lowest-level requester k4", w4, 1 << l0);
  endtask

  task automatic t_starve();
    int waited = 0;
    bit got = 0;
    for (int k = 0; k < 8 && !got; k++) begin
      do_round(4'hf, 8'hff);
      waited++;
      got = w8[0];
    end
    chk(got && waited <= 8, "R9 node0 served within 8 rounds", waited, 8);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_round(4'hf, 8'hff);
    do_round(4'h5, 8'ha5);
    t_hold();
    do_round(4'h0, 8'h00);
    do_round(4'h2, 8'h10);
    t_lone_low();
    for (int i = 0; i < 10; i++)
      do_round(4'((i * 7 + 3) & 15), 8'((i * 29 + 11) & 255));
    t_starve();
    do_round(4'h8, 8'h80);
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule